// File: doc/BRIEF.md
# Serial Disk Membership Engine

This block answers one question for a pixel: does it fall inside a disk of radius 100 centred on a 640 by 480 visible area, at coordinate (320, 240)? A caller presents an unsigned column and row with a one-cycle start pulse. The engine then works through a fixed four-state sequence on a compute clock that runs at twice the pixel clock. It forms the signed offsets from the centre and squares each offset in turn on one shared multiplier. It adds the two squares and compares the sum against the squared radius.

The result comes back as an inside flag with a one-cycle done pulse. The flag keeps its value until the next result replaces it. A start pulse is taken only while the engine is idle, so a caller that pulses start once every four compute clocks gets one answer per request.

Top module: `disk_membership_engine`

## Requirements
- R1: While the synchronous active-high reset is asserted, and in the first cycle after it is released, done_o and inside_o are 0 and the engine is idle.
- R2: For 10-bit unsigned inputs px_i and py_i, a result has inside_o = 1 exactly when (px_i−320)² + (py_i−240)² < 10000, and inside_o = 0 otherwise.
- R3: start_i is sampled only in the IDLE state. A start pulse that arrives while a computation is running is ignored, and it produces neither a second result nor a change to the running result.
- R4: The states run IDLE → SQUARE_X → SQUARE_Y → DECIDE → IDLE, one clock each. done_o is high for exactly one clock, in the fourth cycle after the rising edge that sampled start_i.
- R5: The comparison is strict. A pixel at distance exactly 100 along an axis, such as (420, 240) or (320, 140), reports 0. A pixel such as (419, 240) reports 1.
- R6: Offsets are signed and wide enough for every input. Pixels left of or above the centre are squared correctly, and the far corners (0, 0) and (1023, 1023) report 0 without overflow.
- R7: inside_o keeps the last result until the next done_o pulse, whatever happens meanwhile on px_i and py_i.
- R8: A single product register, fed by one multiplier, holds the x-offset square in SQUARE_Y and the y-offset square in DECIDE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Compute clock (twice the pixel clock) |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request pulse, sampled in IDLE |
| px_i | input | 10 | Pixel column, unsigned |
| py_i | input | 10 | Pixel row, unsigned |
| done_o | output | 1 | One-cycle pulse when a result is ready |
| inside_o | output | 1 | 1 when the last pixel lay strictly inside the disk |

## Verification
The assertions assume that reset is held for at least two clock edges before it is released, so that the registers they compare with $past are already defined. They also assume that start_i is a clean single-cycle pulse. The bench follows both rules: it holds reset for several cycles and drives start_i for exactly one clock at a time. Ignored-start behaviour is exercised on purpose by a pulse placed in the middle of a computation, and the assertions allow for that case because they tie state changes only to start_i sampled in IDLE.

// File: rtl/disk_pkg.sv
package disk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_SQUARE_X = 2'd1,
        ST_SQUARE_Y = 2'd2,
        ST_DECIDE   = 2'd3
    } disk_state_e;

endpackage

// File: rtl/disk_offset.sv
// Signed offset of an unsigned coordinate from a fixed centre.
module disk_offset #(
    parameter int W      = 10,
    parameter int CENTER = 320
) (
    input  logic [W-1:0]      coord,
    output logic signed [W:0] diff
);
    localparam logic signed [W:0] CENTER_S = (W+1)'(CENTER);

    assign diff = $signed({1'b0, coord}) - CENTER_S;
endmodule

// File: rtl/disk_square.sv
// The single multiplier shared by both squares.
module disk_square #(
    parameter int DW = 11
) (
    input  logic signed [DW-1:0]   op,
    output logic signed [2*DW-1:0] sq
);
    logic signed [2*DW-1:0] op_ext;

    assign op_ext = (2*DW)'(op);
    assign sq     = op_ext * op_ext;
endmodule

// File: rtl/disk_below.sv
// Adds two non-negative squares and compares the sum strictly with a limit.
module disk_below #(
    parameter int SW    = 22,
    parameter int LIMIT = 10000
) (
    input  logic [SW-1:0] a,
    input  logic [SW-1:0] b,
    output logic          below
);
    localparam logic [SW:0] LIMIT_W = (SW+1)'(LIMIT);

    logic [SW:0] sum;

    assign sum   = {1'b0, a} + {1'b0, b};
    assign below = (sum < LIMIT_W);
endmodule

// File: rtl/disk_membership_engine.sv
module disk_membership_engine
    import disk_pkg::*;
#(
    parameter int X_BITS   = 10,
    parameter int Y_BITS   = 10,
    parameter int CENTER_X = 320,
    parameter int CENTER_Y = 240,
    parameter int RADIUS   = 100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [X_BITS-1:0] px_i,
    input  logic [Y_BITS-1:0] py_i,
    output logic              done_o,
    output logic              inside_o
);
    localparam int C_BITS = (X_BITS > Y_BITS) ? X_BITS : Y_BITS;
    localparam int OP_W   = C_BITS + 1;
    localparam int SQ_W   = 2 * OP_W;
    localparam int LIMIT  = RADIUS * RADIUS;

    disk_state_e state_q, state_n;

    logic signed [OP_W-1:0] dx_w, dy_w, dx_q, dy_q, op_w;
    logic signed [SQ_W-1:0] sq_w;
    logic [SQ_W-1:0]        acc_q, prod_q;
    logic                   below_w;
    logic                   done_q, inside_q;

    disk_offset #(.W(C_BITS), .CENTER(CENTER_X)) u_off_x (
        .coord (C_BITS'(px_i)),
        .diff  (dx_w)
    );

    disk_offset #(.W(C_BITS), .CENTER(CENTER_Y)) u_off_y (
        .coord (C_BITS'(py_i)),
        .diff  (dy_w)
    );

    // Operand select: the y offset only in SQUARE_Y, the x offset otherwise.
    assign op_w = (state_q == ST_SQUARE_Y) ? dy_q : dx_q;

    disk_square #(.DW(OP_W)) u_square (
        .op (op_w),
        .sq (sq_w)
    );

    disk_below #(.SW(SQ_W), .LIMIT(LIMIT)) u_below (
        .a     (acc_q),
        .b     (prod_q),
        .below (below_w)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_n;
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:     if (start_i) state_n = ST_SQUARE_X;
            ST_SQUARE_X: state_n = ST_SQUARE_Y;
            ST_SQUARE_Y: state_n = ST_DECIDE;
            ST_DECIDE:   state_n = ST_IDLE;
            default:     state_n = ST_IDLE;
        endcase
    end

    // Datapath and outputs; every multiply lands in prod_q.
    always_ff @(posedge clk) begin
        if (rst) begin
            dx_q     <= '0;
            dy_q     <= '0;
            acc_q    <= '0;
            prod_q   <= '0;
            done_q   <= 1'b0;
            inside_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        dx_q <= dx_w;
                        dy_q <= dy_w;
                    end
                end
                ST_SQUARE_X: begin
                    prod_q <= sq_w;
                end
                ST_SQUARE_Y: begin
                    acc_q  <= prod_q;
                    prod_q <= sq_w;
                end
                ST_DECIDE: begin
                    inside_q <= below_w;
                    done_q   <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign done_o   = done_q;
    assign inside_o = inside_q;
endmodule

// File: rtl/disk_membership_checker.sv
module disk_membership_checker
    import disk_pkg::*;
#(
    parameter int OP_W  = 11,
    parameter int LIMIT = 10000
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   start_i,
    input logic                   done_o,
    input logic                   inside_o,
    input disk_state_e            state_q,
    input logic signed [OP_W-1:0] dx_q,
    input logic [2*OP_W-1:0]      acc_q,
    input logic [2*OP_W-1:0]      prod_q
);
    localparam int SQ_W = 2 * OP_W;

    logic signed [SQ_W-1:0] dx_sq;
    logic [SQ_W:0]          pair_sum;

    always_comb begin
        dx_sq    = (SQ_W)'(dx_q) * (SQ_W)'(dx_q);
        pair_sum = {1'b0, acc_q} + {1'b0, prod_q};
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!done_o && !inside_o && state_q == ST_IDLE));

    p_start_taken_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && start_i) |=> state_q == ST_SQUARE_X);

    p_idle_holds_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !start_i) |=> state_q == ST_IDLE);

    p_seq_x_r4: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_SQUARE_X |=> state_q == ST_SQUARE_Y);

    p_seq_y_r4: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_SQUARE_Y |=> state_q == ST_DECIDE);

    p_seq_decide_r4: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_DECIDE |=> (state_q == ST_IDLE && done_o));

    p_done_single_r4: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_inside_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(inside_o));

    p_prod_is_dx_sq_r8: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_SQUARE_Y |-> prod_q == dx_sq);

    p_result_strict_r2: assert property (@(posedge clk) disable iff (rst)
        done_o |-> inside_o == ($past(pair_sum) < (SQ_W+1)'(LIMIT)));
endmodule

bind disk_membership_engine disk_membership_checker #(
    .OP_W  (OP_W),
    .LIMIT (LIMIT)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .done_o   (done_o),
    .inside_o (inside_o),
    .state_q  (state_q),
    .dx_q     (dx_q),
    .acc_q    (acc_q),
    .prod_q   (prod_q)
);

// File: tb/disk_membership_engine_test.sv
module disk_membership_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 16;

    localparam logic [9:0] VX [NV] = '{10'd320, 10'd420, 10'd419, 10'd220,
                                       10'd221, 10'd320, 10'd320, 10'd320,
                                       10'd0,   10'd1023, 10'd390, 10'd391,
                                       10'd260, 10'd261, 10'd250, 10'd380};
    localparam logic [9:0] VY [NV] = '{10'd240, 10'd240, 10'd240, 10'd240,
                                       10'd240, 10'd340, 10'd339, 10'd140,
                                       10'd0,   10'd1023, 10'd310, 10'd311,
                                       10'd160, 10'd160, 10'd180, 10'd300};
    localparam logic       VE [NV] = '{1'b1, 1'b0, 1'b1, 1'b0,
                                       1'b1, 1'b0, 1'b1, 1'b0,
                                       1'b0, 1'b0, 1'b1, 1'b0,
                                       1'b0, 1'b1, 1'b1, 1'b1};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic [9:0] px_i = '0;
    logic [9:0] py_i = '0;
    logic       done_o, inside_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    disk_membership_engine uut (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .px_i     (px_i),
        .py_i     (py_i),
        .done_o   (done_o),
        .inside_o (inside_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one request and check the result timing and value.
    task automatic run_pixel(input logic [9:0] x, input logic [9:0] y,
                             input logic exp, input string tag);
        @(negedge clk);
        px_i = x; py_i = y; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk({tag, " R4 done low before result"}, int'(done_o), 0);
        @(negedge clk);
        chk({tag, " R4 done pulse"}, int'(done_o), 1);
        chk({tag, " result"}, int'(inside_o), int'(exp));
        @(negedge clk);
        chk({tag, " R4 done one clock"}, int'(done_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset done", int'(done_o), 0);
        chk("R1 reset inside", int'(inside_o), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after release", int'(done_o | inside_o), 0);

        // Table walk: R2 main function, R5 strict boundary, R6 signed and corners, R8 shared product
        for (int i = 0; i < NV; i++) begin
            run_pixel(VX[i], VY[i], VE[i], $sformatf("R2 R5 R6 R8 vec%0d", i));
        end

        // R7: result held while inputs wander without start
        run_pixel(10'd321, 10'd241, 1'b1, "R7 setup");
        px_i = 10'd0; py_i = 10'd0;
        repeat (6) @(negedge clk);
        chk("R7 inside held", int'(inside_o), 1);
        chk("R7 no spurious done", int'(done_o), 0);

        // R3: start pulse during a running computation is ignored
        @(negedge clk);
        px_i = 10'd900; py_i = 10'd900; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        px_i = 10'd320; py_i = 10'd240; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        chk("R3 done for first request", int'(done_o), 1);
        chk("R3 result is first request", int'(inside_o), 0);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk("R3 no second done", int'(done_o), 0);
        end

        // R1: reset in mid computation
        run_pixel(10'd320, 10'd240, 1'b1, "R1 setup");
        @(negedge clk);
        px_i = 10'd330; py_i = 10'd250; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R1 mid reset inside", int'(inside_o), 0);
        chk("R1 mid reset done", int'(done_o), 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1 no result after reset", int'(done_o), 0);
        run_pixel(10'd330, 10'd250, 1'b1, "R1 R2 after reset");

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule